// File: doc/BRIEF.md
# HDLC Receive Octet Tagger

This block receives a serial HDLC bit stream, qualified by a one-cycle bit enable. It hunts for the flag pattern and strips the zeros inserted after five ones. It also spots the abort pattern. The surviving bits are gathered into octets, least significant bit first, and each packet is checked against its 16-bit frame check sequence.

Every octet of a packet goes into a 16-entry FIFO, and the FCS octets go in like any other octet. Each entry is marked as the first octet of its packet, the last, both, or neither. The last octet of a packet also carries a two-bit code saying whether the packet was good or why it was rejected.

A host drains the FIFO through a 16-bit read port. It can take whole words, or, in byte mode, take the low half and then the high half of each word.

Top module: `hdlc_rx_tagger`

## Requirements
- R1: Octets are assembled from the de-stuffed stream with the first received bit in data bit 0 and the eighth in bit 7. The flag is the bit pattern 0x7E. A 0 received after exactly five 1s is discarded.
- R2: A read word carries the octet in bits 7:0, the first-octet tag in bit 8, the last-octet tag in bit 9, status bit 0 in bit 10 and status bit 1 in bit 11. Bits 15:12 are zero.
- R3: The first octet after a flag carries the first-octet tag. The octet that precedes the closing flag or abort carries the last-octet tag, whatever the status of the packet.
- R4: On a last-octet entry, status {bit11,bit10} is 00 when the CRC-16 (reflected, polynomial 0x8408, preset 0xFFFF) run over all octets, FCS included, leaves 0xF0B8. It is 01 otherwise. Entries without the last-octet tag hold status 00.
- R5: A packet of one, two or three octets is closed with status 10. A single octet carries both tags. In a two- or three-octet packet, the first octet carries only the first-octet tag and the final octet carries only the last-octet tag.
- R6: A packet whose bit count between flags is not a whole number of octets is closed with status 10.
- R7: Seven consecutive 1s close the open packet, tagging the pending octet as last with status 11. Bits received after that are ignored until the next flag.
- R8: With byte_mode high, rd_data first shows the entry's low byte and then its high byte in bits 7:0, with bits 15:8 zero. The entry leaves the FIFO only on the rd_en that follows the high byte.
- R9: The FIFO holds 16 entries and shows full and empty. A write that arrives while it is full, with no pop in the same cycle, is dropped and sets overflow, which stays set until reset.
- R10: A write and a pop in the same cycle on a full FIFO both take effect. The FIFO stays full and overflow does not change.
- R11: After reset, empty is 1, full is 0, overflow is 0 and rd_data is zero.
- R12: While the FIFO is empty, rd_data reads zero and rd_en has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | Qualifies bit_in for one cycle |
| bit_in | input | 1 | Serial line data |
| byte_mode | input | 1 | 1: read in two byte halves, 0: read whole words |
| rd_en | input | 1 | Host read strobe (advances half or pops) |
| rd_data | output | 16 | Head entry word or the selected byte half |
| fifo_empty | output | 1 | FIFO holds no entry |
| fifo_full | output | 1 | FIFO holds 16 entries |
| overflow | output | 1 | Sticky: an entry was dropped |

## Verification
The write of a closing octet and a host pop can land in the same clock edge. This matters most when the FIFO is full, because the outcome decides whether the octet is kept or lost. The bench fills the FIFO with a 16-octet packet. It then sends a one-octet packet and raises rd_en exactly in the cycle in which the closing write reaches the FIFO. The test is judged by four results: the popped word is the oldest entry, full stays high, overflow stays low, and the tagged single octet appears as the sixteenth entry when the FIFO is drained.

// File: rtl/hdlc_rx_pkg.sv
// Shared types for the HDLC receive tagger: the FIFO entry layout, the
// packet status codes and the bytewise frame check sequence update.
package hdlc_rx_pkg;

    typedef enum logic [1:0] {
        PS_GOOD   = 2'b00,
        PS_BADCRC = 2'b01,
        PS_SHAPE  = 2'b10,
        PS_ABORT  = 2'b11
    } pkt_stat_e;

    // Packed MSB first: stat -> [11:10], last -> [9], first -> [8], data -> [7:0]
    typedef struct packed {
        pkt_stat_e  stat;
        logic       last;
        logic       first;
        logic [7:0] data;
    } rx_entry_t;

    localparam int          ENTRY_W  = $bits(rx_entry_t);
    localparam logic [15:0] FCS_INIT = 16'hFFFF;
    localparam logic [15:0] FCS_GOOD = 16'hF0B8;
    localparam logic [15:0] FCS_POLY = 16'h8408;

    // Reflected CRC-16 update over one octet, bit 0 first.
    function automatic logic [15:0] fcs16_byte(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c ^ {8'h00, d};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ FCS_POLY) : (r >> 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/hdlc_rx_deframer.sv
// Bit-level receiver. Finds flags, deletes stuffed zeros, spots aborts,
// builds octets LSB first and emits one tagged FIFO entry per octet.
// One octet is held back so the octet before a closing flag can be
// marked as last. Assumes at most one bit_en per cycle; the output
// strobe is registered, one cycle after the bit that caused it.
module hdlc_rx_deframer
    import hdlc_rx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_en,
    input  logic      bit_in,
    output logic      wr_valid,
    output rx_entry_t wr_entry
);

    logic        in_frame;
    logic [2:0]  ones;
    logic [2:0]  bitcnt;
    logic [7:0]  shreg;
    logic        pend_v;
    logic        pend_first;
    logic [7:0]  pend;
    logic [1:0]  octs;
    logic [15:0] crc;

    logic        ev_flag, ev_abort, ev_stuff, ev_take, ev_octet, ev_close;
    logic [7:0]  sh_next;
    logic [15:0] crc_pend;
    pkt_stat_e   close_stat;

    // Classify the current bit and work out the closing status.
    always_comb begin
        ev_flag  = bit_en && !bit_in && (ones == 3'd6);
        ev_abort = bit_en && bit_in && (ones >= 3'd6);
        ev_stuff = bit_en && !bit_in && (ones == 3'd5);
        ev_take  = bit_en && in_frame && !ev_flag && !ev_abort && !ev_stuff;
        sh_next  = {bit_in, shreg[7:1]};
        ev_octet = ev_take && (bitcnt == 3'd7);
        ev_close = (ev_flag || ev_abort) && in_frame && pend_v;
        crc_pend = fcs16_byte(crc, pend);
        if (bitcnt != 3'd7 || octs != 2'd3) begin
            close_stat = PS_SHAPE;
        end else if (crc_pend == FCS_GOOD) begin
            close_stat = PS_GOOD;
        end else begin
            close_stat = PS_BADCRC;
        end
    end

    // Track the run of ones, the framing state and the octet shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ones     <= 3'd0;
            in_frame <= 1'b0;
            bitcnt   <= 3'd0;
            shreg    <= 8'h00;
        end else if (bit_en) begin
            ones <= bit_in ? ((ones == 3'd7) ? 3'd7 : ones + 3'd1) : 3'd0;
            if (ev_flag) begin
                in_frame <= 1'b1;
                bitcnt   <= 3'd0;
            end else if (ev_abort) begin
                in_frame <= 1'b0;
            end else if (ev_take) begin
                bitcnt <= bitcnt + 3'd1;
                shreg  <= sh_next;
            end
        end
    end

    // Hold back one octet and keep the running count and CRC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v     <= 1'b0;
            pend_first <= 1'b0;
            pend       <= 8'h00;
            octs       <= 2'd0;
            crc        <= FCS_INIT;
        end else if (ev_flag || ev_abort) begin
            pend_v <= 1'b0;
            octs   <= 2'd0;
            crc    <= FCS_INIT;
        end else if (ev_octet) begin
            pend       <= sh_next;
            pend_v     <= 1'b1;
            pend_first <= !pend_v && (octs == 2'd0);
            if (pend_v) begin
                crc  <= crc_pend;
                octs <= (octs == 2'd3) ? 2'd3 : octs + 2'd1;
            end
        end
    end

    // Emit the held octet, plain or as the tagged closing entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_entry <= '0;
        end else begin
            wr_valid <= 1'b0;
            if (ev_octet && pend_v) begin
                wr_valid <= 1'b1;
                wr_entry <= '{stat: PS_GOOD, last: 1'b0, first: pend_first, data: pend};
            end else if (ev_close) begin
                wr_valid <= 1'b1;
                wr_entry <= '{stat: (ev_abort ? PS_ABORT : close_stat), last: 1'b1,
                              first: pend_first, data: pend};
            end
        end
    end

    // R4: only a closing entry may carry a non-zero status
    p_mid_stat_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_entry.last) |-> (wr_entry.stat == PS_GOOD));

    // R5: a one-octet packet is never reported good
    p_single_invalid_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_entry.first && wr_entry.last) |-> (wr_entry.stat != PS_GOOD));

    // R3: a flag or abort with an octet held produces a closing entry next cycle
    p_close_tagged_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_close |=> (wr_valid && wr_entry.last));

    // R7: an abort leaves the receiver hunting
    p_abort_hunt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abort |=> !in_frame);

endmodule

// File: rtl/hdlc_rx_fifo.sv
// Tagged-entry FIFO. Pops before pushes, so a full FIFO accepts a write
// in the cycle it is popped. A write that still finds no room is dropped
// and latches a sticky overflow flag. Storage is not reset.
module hdlc_rx_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full,
    output logic             overflow
);

    localparam int            AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW:0]   CNT_F = (AW + 1)'(DEPTH);
    localparam logic [AW-1:0] LAST  = AW'(DEPTH - 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic [AW:0]      cnt;
    logic             pop_ok, push_ok;

    // Decide which of the requested operations take effect.
    always_comb begin
        pop_ok  = pop && (cnt != '0);
        push_ok = push && ((cnt != CNT_F) || pop_ok);
        empty   = (cnt == '0);
        full    = (cnt == CNT_F);
        head    = mem[rp];
    end

    // Write storage.
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wp] <= push_data;
        end
    end

    // Move pointers, occupancy and the sticky overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp       <= '0;
            rp       <= '0;
            cnt      <= '0;
            overflow <= 1'b0;
        end else begin
            if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
            if (pop_ok)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
            if (push_ok && !pop_ok)      cnt <= cnt + 1'b1;
            else if (pop_ok && !push_ok) cnt <= cnt - 1'b1;
            if (push && !push_ok) overflow <= 1'b1;
        end
    end

    // R9: a write onto a full FIFO with no pop keeps it full and flags overflow
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> (full && overflow));

    // R10: a write and pop on a full FIFO keep it full and leave overflow alone
    p_full_swap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && pop) |=> (full && (overflow == $past(overflow))));

    // R12: a pop request on an empty FIFO moves nothing
    p_empty_pop_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop) |=> (rp == $past(rp)));

    // R9: overflow never clears outside reset
    p_sticky_ovf_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

endmodule

// File: rtl/hdlc_rx_hostport.sv
// Host read side. Presents the head entry as a 16-bit word, or in byte
// mode as the low half followed by the high half. Requests a FIFO pop on
// a word read, or on the read of the high half. Reads zero while empty.
module hdlc_rx_hostport #(
    parameter int ENTRY_W = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_mode,
    input  logic               rd_en,
    input  logic [ENTRY_W-1:0] head,
    input  logic               empty,
    output logic               pop,
    output logic [15:0]        rd_data
);

    localparam int PAD_W = 16 - ENTRY_W;

    logic        hi_phase;
    logic [15:0] word;

    // Form the visible word and the pop request.
    always_comb begin
        word = empty ? 16'h0000 : {{PAD_W{1'b0}}, head};
        if (!byte_mode)    rd_data = word;
        else if (hi_phase) rd_data = {8'h00, word[15:8]};
        else               rd_data = {8'h00, word[7:0]};
        pop = rd_en && !empty && (!byte_mode || hi_phase);
    end

    // Toggle between low and high half in byte mode.
    always_ff @(posedge clk) begin
        if (!rst_n || !byte_mode) begin
            hi_phase <= 1'b0;
        end else if (rd_en && !empty) begin
            hi_phase <= !hi_phase;
        end
    end

    // R8: reading the low half never pops
    p_low_no_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_mode && !hi_phase) |-> !pop);

endmodule

// File: rtl/hdlc_rx_tagger.sv
// Top of the HDLC receive tagger: deframer into a tagged FIFO, drained
// through the host read port. Assumes bit_en and host strobes are
// synchronous to clk.
module hdlc_rx_tagger
    import hdlc_rx_pkg::*;
#(
    parameter int FIFO_DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_en,
    input  logic        bit_in,
    input  logic        byte_mode,
    input  logic        rd_en,
    output logic [15:0] rd_data,
    output logic        fifo_empty,
    output logic        fifo_full,
    output logic        overflow
);

    logic               wr_valid;
    rx_entry_t          wr_entry;
    logic               pop;
    logic [ENTRY_W-1:0] head;

    hdlc_rx_deframer u_deframer (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .bit_in   (bit_in),
        .wr_valid (wr_valid),
        .wr_entry (wr_entry)
    );

    hdlc_rx_fifo #(
        .DEPTH (FIFO_DEPTH),
        .WIDTH (ENTRY_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_valid),
        .push_data (wr_entry),
        .pop       (pop),
        .head      (head),
        .empty     (fifo_empty),
        .full      (fifo_full),
        .overflow  (overflow)
    );

    hdlc_rx_hostport #(
        .ENTRY_W (ENTRY_W)
    ) u_host (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_mode (byte_mode),
        .rd_en     (rd_en),
        .head      (head),
        .empty     (fifo_empty),
        .pop       (pop),
        .rd_data   (rd_data)
    );

endmodule

// File: tb/tb_hdlc_rx_tagger.sv
// Directed bench for the HDLC receive tagger. Each task drives one
// scenario and checks its own results against words built from the
// requirements.
module tb_hdlc_rx_tagger;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_en = 1'b0;
    logic        bit_in = 1'b1;
    logic        byte_mode = 1'b0;
    logic        rd_en = 1'b0;
    logic [15:0] rd_data;
    logic        fifo_empty, fifo_full, overflow;

    int n_chk = 0;
    int n_fail = 0;
    int tx_ones = 0;
    bit done = 1'b0;

    logic [7:0]  fb    [0:31];
    logic [15:0] exp_w [0:63];
    logic [15:0] exp_m [0:63];
    int exp_n = 0;
    int exp_rd = 0;

    always #4 clk = ~clk;

    hdlc_rx_tagger dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .bit_in     (bit_in),
        .byte_mode  (byte_mode),
        .rd_en      (rd_en),
        .rd_data    (rd_data),
        .fifo_empty (fifo_empty),
        .fifo_full  (fifo_full),
        .overflow   (overflow)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] tb_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            logic fbk = r[0] ^ d[i];
            r = r >> 1;
            if (fbk) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    task automatic add_exp(input logic [7:0] d, input bit first, input bit last,
                           input logic [1:0] st, input logic [15:0] mask);
        exp_w[exp_n] = {4'h0, st, last, first, d};
        exp_m[exp_n] = mask;
        exp_n++;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0; bit_en = 1'b0; bit_in = 1'b1; rd_en = 1'b0; byte_mode = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tx_ones = 0; exp_n = 0; exp_rd = 0;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); bit_en = 1'b1; bit_in = b;
        @(negedge clk); bit_en = 1'b0;
    endtask

    // Last bit of the closing flag with rd_en raised in the FIFO write cycle.
    task automatic send_bit_pop(input logic b, output logic [15:0] seen);
        @(negedge clk); bit_en = 1'b1; bit_in = b;
        @(negedge clk); bit_en = 1'b0; seen = rd_data; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic send_byte(input logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            send_bit(d[i]);
            if (d[i]) tx_ones++; else tx_ones = 0;
            if (tx_ones == 5) begin
                send_bit(1'b0);
                tx_ones = 0;
            end
        end
    endtask

    task automatic send_flag();
        for (int i = 0; i < 8; i++) send_bit((8'h7E >> i) & 1);
        tx_ones = 0;
    endtask

    // Sends fb[0..n-1] (+FCS), closing flag, and records the expected entries.
    task automatic send_frame(input int n, input bit with_fcs, input bit corrupt,
                              input logic [1:0] st);
        logic [15:0] c = 16'hFFFF;
        logic [7:0]  tx [0:33];
        int total = n;
        for (int i = 0; i < n; i++) begin
            c = tb_crc(c, fb[i]);
            tx[i] = fb[i];
        end
        if (with_fcs) begin
            tx[n] = ~c[7:0]; tx[n+1] = ~c[15:8]; total = n + 2;
        end
        if (corrupt) tx[0] = tx[0] ^ 8'h01;
        for (int i = 0; i < total; i++) begin
            send_byte(tx[i]);
            add_exp(tx[i], i == 0, i == total - 1, (i == total - 1) ? st : 2'b00, 16'hFFFF);
        end
    endtask

    task automatic read_word(output logic [15:0] w);
        @(negedge clk); w = rd_data; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic drain(input string req);
        logic [15:0] w;
        repeat (4) @(negedge clk);
        for (int i = exp_rd; i < exp_n; i++) begin
            read_word(w);
            chk(req, w & exp_m[i], exp_w[i] & exp_m[i]);
        end
        @(negedge clk);
        chk({req, " empty after drain"}, {15'd0, fifo_empty}, 16'd1);
        exp_n = 0; exp_rd = 0;
    endtask

    task automatic t_reset();
        chk("R11 empty", {15'd0, fifo_empty}, 16'd1);
        chk("R11 full", {15'd0, fifo_full}, 16'd0);
        chk("R11 overflow", {15'd0, overflow}, 16'd0);
        chk("R11 rd_data", rd_data, 16'h0000);
    endtask

    task automatic t_good_frame();
        send_flag();
        fb[0] = 8'hFF; fb[1] = 8'h7E; fb[2] = 8'h01; fb[3] = 8'h80;
        send_frame(4, 1'b1, 1'b0, 2'b00);
        send_flag();
        drain("R1 R2 R3 R4 good frame");
    endtask

    task automatic t_bad_crc();
        send_flag();
        fb[0] = 8'h5A; fb[1] = 8'h3F; fb[2] = 8'hF8; fb[3] = 8'h00; fb[4] = 8'hC7;
        send_frame(5, 1'b1, 1'b1, 2'b01);
        send_flag();
        drain("R4 crc error");
    endtask

    task automatic t_runts();
        send_flag();
        fb[0] = 8'h81;
        send_frame(1, 1'b0, 1'b0, 2'b10);
        send_flag();
        fb[0] = 8'h42; fb[1] = 8'h24;
        send_frame(2, 1'b0, 1'b0, 2'b10);
        send_flag();
        fb[0] = 8'h11; fb[1] = 8'hEE; fb[2] = 8'h99;
        send_frame(3, 1'b0, 1'b0, 2'b10);
        send_flag();
        drain("R5 runt tagging");
    endtask

    task automatic t_nonintegral();
        send_flag();
        fb[0] = 8'h10; fb[1] = 8'h20; fb[2] = 8'h30; fb[3] = 8'h40;
        for (int i = 0; i < 4; i++) begin
            send_byte(fb[i]);
            add_exp(fb[i], i == 0, 1'b0, 2'b00, 16'hFFFF);
        end
        for (int i = 0; i < 3; i++) send_bit(1'b0);
        tx_ones = 0;
        add_exp(8'h00, 1'b0, 1'b1, 2'b10, 16'h0F00);
        send_flag();
        drain("R6 non-integral");
    endtask

    task automatic t_abort();
        send_flag();
        fb[0] = 8'h11; fb[1] = 8'h22; fb[2] = 8'h33; fb[3] = 8'h44; fb[4] = 8'h12;
        send_frame(5, 1'b0, 1'b0, 2'b11);
        for (int i = 0; i < 7; i++) send_bit(1'b1);
        send_byte(8'h55); send_byte(8'hAA); send_byte(8'h0F);
        repeat (4) @(negedge clk);
        chk("R7 nothing stored after abort", {15'd0, fifo_empty}, 16'd0);
        send_flag();
        fb[0] = 8'hC3; fb[1] = 8'h3C; fb[2] = 8'h96; fb[3] = 8'h69;
        send_frame(4, 1'b1, 1'b0, 2'b00);
        send_flag();
        drain("R7 abort then recovery");
    endtask

    task automatic t_byte_mode();
        logic [15:0] w;
        send_flag();
        fb[0] = 8'h3C; fb[1] = 8'hC3;
        send_frame(2, 1'b0, 1'b0, 2'b10);
        send_flag();
        repeat (4) @(negedge clk);
        byte_mode = 1'b1;
        read_word(w); chk("R8 low byte entry0", w, 16'h003C);
        @(negedge clk);
        chk("R8 no pop after low byte", rd_data, 16'h0001);
        read_word(w); chk("R8 high byte entry0", w, 16'h0001);
        read_word(w); chk("R8 low byte entry1", w, 16'h00C3);
        read_word(w); chk("R8 high byte entry1", w, 16'h000A);
        @(negedge clk);
        chk("R8 empty after two entries", {15'd0, fifo_empty}, 16'd1);
        byte_mode = 1'b0;
        exp_n = 0; exp_rd = 0;
    endtask

    task automatic t_empty_read();
        @(negedge clk);
        chk("R12 rd_data zero when empty", rd_data, 16'h0000);
        rd_en = 1'b1;
        repeat (2) @(negedge clk);
        rd_en = 1'b0;
        send_flag();
        fb[0] = 8'hE7;
        send_frame(1, 1'b0, 1'b0, 2'b10);
        send_flag();
        drain("R12 empty read ignored");
    endtask

    task automatic t_overflow();
        apply_reset();
        send_flag();
        for (int i = 0; i < 14; i++) fb[i] = 8'(i * 17 + 3);
        send_frame(14, 1'b1, 1'b0, 2'b00);
        send_flag();
        send_byte(8'h66);
        send_flag();
        repeat (4) @(negedge clk);
        chk("R9 full", {15'd0, fifo_full}, 16'd1);
        chk("R9 overflow set", {15'd0, overflow}, 16'd1);
        drain("R9 first 16 kept");
        chk("R9 overflow sticky", {15'd0, overflow}, 16'd1);
    endtask

    task automatic t_full_swap();
        logic [15:0] seen;
        apply_reset();
        send_flag();
        for (int i = 0; i < 14; i++) fb[i] = 8'(i * 29 + 5);
        send_frame(14, 1'b1, 1'b0, 2'b00);
        send_flag();
        repeat (4) @(negedge clk);
        chk("R9 full after 16", {15'd0, fifo_full}, 16'd1);
        send_byte(8'hA5);
        add_exp(8'hA5, 1'b1, 1'b1, 2'b10, 16'hFFFF);
        for (int i = 0; i < 7; i++) send_bit((8'h7E >> i) & 1);
        send_bit_pop(1'b0, seen);
        tx_ones = 0;
        chk("R10 popped oldest", seen, exp_w[0]);
        exp_rd = 1;
        @(negedge clk);
        chk("R10 still full", {15'd0, fifo_full}, 16'd1);
        chk("R10 no overflow", {15'd0, overflow}, 16'd0);
        drain("R10 write kept");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        apply_reset();
        t_reset();
        t_good_frame();
        t_bad_crc();
        t_runts();
        t_nonintegral();
        t_abort();
        t_byte_mode();
        t_empty_read();
        t_overflow();
        t_full_swap();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule